// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for each incoming Ethernet frame, whether the frame is kept. It looks only at the 48-bit destination address. The caller presents that address together with a one-cycle strobe. One clock later the block returns an accept flag and a classification word, which a receive path can copy into its per-frame status.

The address is tested in four ways:
- against four exact-match slots. Slot 0 normally holds the station's own address, and slots 1 to 3 hold selected group addresses.
- against a 64-bit group hash table, indexed by six bits of the address's Ethernet CRC-32.
- for the all-ones broadcast address.
- for the group bit in the first address byte.

A control word turns reception, promiscuous operation and hash lookup on and off. All control and table state is loaded through a simple 16-bit register write port. Frame storage and DMA sit outside this block.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, the control word, all slots and all hash words are zero, and `res_valid`, `res_accept` and `res_status` are all zero.
- R2: A frame strobed on `frame_valid` at one rising edge produces `res_valid` high for exactly the following cycle, with `res_accept` and `res_status` valid in that cycle.
- R3: When control bit 1 (receive enable) is clear, `res_accept` is 0 for every address, while the classification bits in `res_status` are still produced.
- R4: With receive enabled, the all-ones address is accepted. It sets status bit 5 (broadcast), and it sets neither status bit 4 (group) nor status bit 3 (hash hit).
- R5: A slot matches when it is nonzero and equals the destination. A matching slot sets status bit 2 and puts the slot number in status bits 1:0. An all-zero slot never matches. When no slot matches, bits 1:0 are 0.
- R6: When several slots hold the matching address, the lowest-numbered slot is reported.
- R7: Status bit 4 (group) is set when the least significant bit of the first destination byte, `frame_dest[40]`, is 1 and the address is not all ones.
- R8: When control bit 8 (hash enable) is set, a group frame with no slot match sets status bit 3 and is accepted if its table bit is set. The hash h is bits 31:26 of the CRC-32. The CRC uses polynomial 0x04C11DB7, starts at all ones, is not inverted, and processes the six bytes from `frame_dest[47:40]` down to `frame_dest[7:0]`, each byte least significant bit first. The table bit is bit h[3:0] of hash word h[5:4]. With hash enable clear, bit 3 is never set.
- R9: An exact slot hit takes priority over the hash: when status bit 2 is set, status bit 3 is clear.
- R10: When control bit 5 (promiscuous) and receive enable are both set, every frame is accepted, and the classification bits are unchanged.
- R11: Register map, in byte offsets: the control word is at 0x00. Slot k's words are at 0x10+8k (bytes 1,0 of the address, first byte in bits 7:0), +2 (bytes 3,2) and +4 (bytes 5,4). Hash word i is at 0x30+2i. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 8 | Register byte offset |
| cfg_wr_data | input | 16 | Register write data |
| frame_valid | input | 1 | Destination address strobe |
| frame_dest | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_status | output | 6 | {broadcast, group, hash hit, slot hit, slot index[1:0]} |

## Verification
The checks assume that the control word used for a frame is the one already in the register at the strobe edge. A write in the same cycle as a strobe only takes effect for later frames. The stimulus therefore never writes and strobes in the same cycle: every register write finishes a full cycle before the next address is presented. Strobes are also kept apart by at least one idle cycle, so each `res_valid` pulse belongs to a single frame. No frame is strobed while the internal reset is still being released.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int WORD_W        = 16;
  localparam int ADDR_BITS     = 48;
  localparam int ADDR_BYTES    = ADDR_BITS / 8;
  localparam int WORDS_PER_ENT = 3;
  localparam int CTRL_RX_BIT   = 1;
  localparam int CTRL_PROM_BIT = 5;
  localparam int CTRL_HASH_BIT = 8;
  localparam int CTRL_OFS      = 'h00;
  localparam int ENTRY_BASE    = 'h10;
  localparam int ENTRY_STRIDE  = 8;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int HASH_WORDS  = 4,
  parameter int AW          = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [AW-1:0]                         wr_addr,
  input  logic [WORD_W-1:0]                     wr_data,
  output logic [WORD_W-1:0]                     ctrl_o,
  output logic [NUM_ENTRIES-1:0][ADDR_BITS-1:0] entry_o,
  output logic [HASH_WORDS-1:0][WORD_W-1:0]     hash_o
);
  localparam int NWORDS    = NUM_ENTRIES * WORDS_PER_ENT;
  localparam int HASH_BASE = ENTRY_BASE + ENTRY_STRIDE * NUM_ENTRIES;

  logic [WORD_W-1:0]             ctrl_q, ctrl_d;
  logic [NWORDS-1:0][WORD_W-1:0] word_q, word_d;
  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_q, hash_d;

  always_comb begin
    ctrl_d = ctrl_q;
    word_d = word_q;
    hash_d = hash_q;
    if (wr_addr == AW'(CTRL_OFS)) ctrl_d = wr_data;
    for (int i = 0; i < HASH_WORDS; i++)
      if (wr_addr == AW'(HASH_BASE + 2 * i)) hash_d[i] = wr_data;
    for (int k = 0; k < NUM_ENTRIES; k++)
      for (int w = 0; w < WORDS_PER_ENT; w++)
        if (wr_addr == AW'(ENTRY_BASE + ENTRY_STRIDE * k + 2 * w))
          word_d[k*WORDS_PER_ENT+w] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      word_q <= '0;
      hash_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      word_q <= word_d;
      hash_q <= hash_d;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_ENTRIES; k++) begin : g_ent
      // low word carries the first two address bytes, first byte in bits 7:0
      assign entry_o[k] = {word_q[k*3][7:0],   word_q[k*3][15:8],
                           word_q[k*3+1][7:0], word_q[k*3+1][15:8],
                           word_q[k*3+2][7:0], word_q[k*3+2][15:8]};
    end
  endgenerate

  assign ctrl_o = ctrl_q;
  assign hash_o = hash_q;
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic [ADDR_BITS-1:0] addr,
  output logic [HASH_BITS-1:0] hash
);
  logic [31:0] crc;
  logic        fb;

  always_comb begin
    crc = '1;
    fb  = 1'b0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      for (int i = 0; i < 8; i++) begin
        fb  = crc[31] ^ addr[ADDR_BITS-8-8*b+i];
        crc = {crc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
      end
    end
  end

  assign hash = crc[31 -: HASH_BITS];
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
  import rxf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic [NUM_ENTRIES-1:0][ADDR_BITS-1:0] entry,
  input  logic [ADDR_BITS-1:0]                  addr,
  output logic                                  hit,
  output logic [IDX_W-1:0]                      idx
);
  logic [NUM_ENTRIES-1:0] eq;

  genvar k;
  generate
    for (k = 0; k < NUM_ENTRIES; k++) begin : g_cmp
      assign eq[k] = (entry[k] != '0) && (entry[k] == addr);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int j = NUM_ENTRIES - 1; j >= 0; j--)
      if (eq[j]) idx = IDX_W'(j);
  end

  assign hit = |eq;
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int HASH_BITS   = 6,
  parameter int AW          = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int ST_W       = 4 + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [AW-1:0]        cfg_wr_addr,
  input  logic [WORD_W-1:0]    cfg_wr_data,
  input  logic                 frame_valid,
  input  logic [ADDR_BITS-1:0] frame_dest,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [ST_W-1:0]      res_status
);
  localparam int HASH_WORDS = (2 ** HASH_BITS) / WORD_W;
  localparam int SEL_W      = HASH_BITS - 4;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [WORD_W-1:0]                     cfg_ctrl;
  logic [NUM_ENTRIES-1:0][ADDR_BITS-1:0] cfg_entry;
  logic [HASH_WORDS-1:0][WORD_W-1:0]     cfg_hash;

  rxf_cfg_regs #(.NUM_ENTRIES(NUM_ENTRIES), .HASH_WORDS(HASH_WORDS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .ctrl_o(cfg_ctrl), .entry_o(cfg_entry), .hash_o(cfg_hash)
  );

  logic [HASH_BITS-1:0] hval;
  rxf_crc_hash #(.HASH_BITS(HASH_BITS)) u_crc (.addr(frame_dest), .hash(hval));

  logic             ex_hit;
  logic [IDX_W-1:0] ex_idx;
  rxf_exact_match #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_match (
    .entry(cfg_entry), .addr(frame_dest), .hit(ex_hit), .idx(ex_idx)
  );

  logic            is_bcast, is_mcast, tab_bit, hash_hit, accept_d;
  logic [SEL_W-1:0] word_sel;
  logic [3:0]       bit_sel;
  logic [ST_W-1:0]  status_d;

  always_comb begin
    is_bcast = &frame_dest;
    is_mcast = frame_dest[ADDR_BITS-8] & ~is_bcast;
    word_sel = hval[HASH_BITS-1:4];
    bit_sel  = hval[3:0];
    tab_bit  = cfg_hash[word_sel][bit_sel];
    hash_hit = cfg_ctrl[CTRL_HASH_BIT] & is_mcast & tab_bit & ~ex_hit;
    accept_d = cfg_ctrl[CTRL_RX_BIT] &
               (cfg_ctrl[CTRL_PROM_BIT] | is_bcast | ex_hit | hash_hit);
    status_d = {is_bcast, is_mcast, hash_hit, ex_hit, ex_idx};
  end

  logic            valid_q, accept_q;
  logic [ST_W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      status_q <= '0;
    end else begin
      valid_q <= frame_valid;
      if (frame_valid) begin
        accept_q <= accept_d;
        status_q <= status_d;
      end
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = accept_q;
  assign res_status = status_q;
endmodule

// File: rtl/rxf_addr_filter_chk.sv
module rxf_addr_filter_chk #(
  parameter int ST_W  = 6,
  parameter int IDX_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_valid,
  input logic [47:0]     frame_dest,
  input logic [15:0]     ctrl,
  input logic            res_valid,
  input logic            res_accept,
  input logic [ST_W-1:0] res_status
);
  // R2
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> res_valid);
  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> !res_valid);
  // R3
  rx_off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !ctrl[1]) |=> !res_accept);
  // R4
  bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && (&frame_dest) && ctrl[1]) |=> (res_accept && res_status[ST_W-1]));
  // R10
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ctrl[1] && ctrl[5]) |=> res_accept);
  // R9
  exact_over_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_status[ST_W-3] && res_status[ST_W-4]));
  // R5
  idx_zero_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_status[ST_W-4]) |-> (res_status[IDX_W-1:0] == '0));
endmodule

bind rxf_addr_filter rxf_addr_filter_chk #(.ST_W(ST_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sync), .frame_valid(frame_valid), .frame_dest(frame_dest),
  .ctrl(cfg_ctrl), .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
);

// File: tb/rxf_addr_filter_test.sv
module rxf_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        fv = 1'b0;
  logic [47:0] dest = '0;
  logic        r_valid, r_acc;
  logic [5:0]  r_st;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cycles = 0;

  logic [15:0] m_ctrl = '0;
  logic [47:0] m_ent [4];
  logic [15:0] m_tab [4];

  always #10 clk = ~clk;

  rxf_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_addr(wr_addr),
    .cfg_wr_data(wr_data), .frame_valid(fv), .frame_dest(dest),
    .res_valid(r_valid), .res_accept(r_acc), .res_status(r_st)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [5:0] hash6(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic b = d[40 - 8 * (n / 8) + (n % 8)];
      logic t = c[31] ^ b;
      c = c << 1;
      if (t) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [6:0] model(input logic [47:0] d);
    logic bc = &d;
    logic mc = d[40] && !bc;
    logic ex = 0;
    logic [1:0] ix = 0;
    logic [5:0] h = hash6(d);
    logic hh;
    logic acc;
    for (int k = 3; k >= 0; k--)
      if (m_ent[k] != 0 && m_ent[k] == d) begin ex = 1; ix = 2'(k); end
    hh  = m_ctrl[8] && mc && m_tab[h[5:4]][h[3:0]] && !ex;
    acc = m_ctrl[1] && (m_ctrl[5] || bc || ex || hh);
    return {acc, bc, mc, hh, ex, ix};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_ctrl(input logic [15:0] v);
    wr(8'h00, v); m_ctrl = v;
  endtask

  task automatic set_entry(input int k, input logic [47:0] a);
    wr(8'(16 + 8 * k), {a[39:32], a[47:40]});
    wr(8'(18 + 8 * k), {a[23:16], a[31:24]});
    wr(8'(20 + 8 * k), {a[7:0], a[15:8]});
    m_ent[k] = a;
  endtask

  task automatic set_tab(input int i, input logic [15:0] v);
    wr(8'(8'h30 + 2 * i), v); m_tab[i] = v;
  endtask

  task automatic send(input logic [47:0] d, input string req);
    logic [6:0] e = model(d);
    @(negedge clk); fv = 1; dest = d;
    @(negedge clk); fv = 0;
    check(req, {r_valid, r_acc, r_st}, {1'b1, e});
  endtask

  logic [47:0] mc_list [8];

  initial begin
    for (int k = 0; k < 4; k++) begin m_ent[k] = '0; m_tab[k] = '0; end
    mc_list[0] = 48'h01005E000001; mc_list[1] = 48'h333300000001;
    mc_list[2] = 48'h01005E7FFFFA; mc_list[3] = 48'h0180C2000000;
    mc_list[4] = 48'h03000000ABCD; mc_list[5] = 48'hFFFFFFFFFFFE;
    mc_list[6] = 48'h0900_2B00_0004; mc_list[7] = 48'h01AB_CDEF_0123;

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", {r_valid, r_acc, r_st}, 8'h00);

    // R3 receive disabled: classification only
    send(48'hFFFFFFFFFFFF, "R3 R1");
    send(48'h021122334455, "R3");
    // R2 pulse lasts one cycle
    @(negedge clk);
    check("R2", {7'b0, r_valid}, 8'h00);

    set_ctrl(16'h0002);
    send(48'hFFFFFFFFFFFF, "R4");
    send(48'h000000000000, "R5 zero slot");
    set_entry(0, 48'h021122334455);
    send(48'h021122334455, "R5");
    for (int b = 0; b < 48; b++) send(48'h021122334455 ^ (48'h1 << b), "R5 R7 bitflip");

    set_entry(1, 48'h01005E000001);
    set_entry(2, 48'h01005E000001);
    set_entry(3, 48'h01005E000001);
    send(48'h01005E000001, "R6");
    set_entry(1, 48'h0);
    send(48'h01005E000001, "R6 R5");

    // R8 hash sweep over every table bit
    set_ctrl(16'h0102);
    for (int hb = 0; hb < 64; hb++) begin
      for (int i = 0; i < 4; i++) set_tab(i, (i == hb / 16) ? 16'(1 << (hb % 16)) : 16'h0);
      for (int j = 0; j < 8; j++) send(mc_list[j], "R8 R7");
    end
    for (int i = 0; i < 4; i++) set_tab(i, 16'hFFFF);
    for (int j = 0; j < 8; j++) send(mc_list[j], "R8 all");
    send(48'h01005E000001, "R9");
    send(48'hFFFFFFFFFFFF, "R4 hash on");
    set_ctrl(16'h0002);
    send(48'h333300000001, "R8 disabled");

    // R10 promiscuous
    set_ctrl(16'h0022);
    send(48'h0A0B0C0D0E0F, "R10");
    send(48'h333300000001, "R10");
    send(48'h021122334455, "R10");
    set_ctrl(16'h0020);
    send(48'h0A0B0C0D0E0F, "R10 R3");

    // R11 unmapped offsets leave state alone
    set_ctrl(16'h0002);
    wr(8'h16, 16'hFFFF);
    wr(8'h02, 16'hFFFF);
    wr(8'h2E, 16'h1234);
    wr(8'h11, 16'h5555);
    send(48'h021122334455, "R11");
    send(48'h0A0B0C0D0E0F, "R11");
    send(48'h01005E000001, "R11");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule